// File: doc/BRIEF.md
# Fractional Symbol-Rate Sample Selector

This block thins an oversampled sample stream down to a fixed count of samples per symbol. A programmable spacing, held as an unsigned fixed-point number with an integer part and a fractional part, sets how many input samples lie between two chosen outputs on average. A fractional phase register accumulates the fractional part at every selection. Each step between selections moves forward by the integer part, or by one more than that whenever the phase register wraps past one.

Every chosen sample leaves the block together with the phase value that was current when it was picked. A downstream interpolator uses that value to place the true sampling instant between two input samples.

Chosen samples are also collected into groups of four and presented in time order on one wide bus. A one-cycle strobe marks each complete group. Logic that runs at the symbol rate further down the chain is enabled only by that strobe and stays idle at all other times. The loop that corrects the spacing from a timing error measure lies outside this block. That loop only writes the spacing input.

Top module: `symbol_sample_selector`

## Requirements
- R1: A synchronous active-high reset clears `sel_valid`, `sym_valid`, `sel_frac`, the phase register and the group slot. The first valid input after reset is selected, and it carries offset 0.
- R2: Only a cycle with `in_valid` high can produce a selection, and at most one sample is taken per clock. While `in_valid` is low, the skip count and the phase register hold.
- R3: `interval` is Q4.12: bits [15:12] hold the integer part and bits [11:0] the fraction. At each selection the 12-bit phase register adds the fraction modulo 4096. The next selection comes `int + carry` valid inputs later, where carry is 1 when the sum reached 4096. For example, with 0x44CD the spacings are 4, 4, 4, 5.
- R4: `sel_frac` equals the phase register value before the add that belongs to that selection.
- R5: An integer part of 0 is treated as 1, so the spacing is 1 or 2 inputs.
- R6: A change of `interval` is used at the next selection decision. A skip count that was already loaded is not changed by it.
- R7: Slot k of each group of four is `sym_vec[12k+11:12k]`, with slot 0 being the oldest sample. `sym_valid` is high for exactly one cycle per group, in the same cycle as the fourth `sel_valid`.
- R8: `sel_valid`, `sel_data` and `sel_frac` appear one clock after the edge that accepts the selected input. `sel_data` and `sel_frac` hold until the next selection.
- R9: A reset in the middle of a stream discards a partly filled group. The next group starts again at slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 12 | Input sample |
| interval | input | 16 | Spacing, Q4.12 unsigned |
| sel_valid | output | 1 | A selected sample is presented |
| sel_data | output | 12 | Selected sample |
| sel_frac | output | 12 | Fractional offset of the selected sample |
| sym_valid | output | 1 | Symbol-ready strobe |
| sym_vec | output | 48 | Four stacked samples, slot 0 in the low bits |

## Verification
Each input the bench applies is accepted at one rising edge. The selection outputs for that input, and the strobe together with the stacked vector when it completes a group, are all due right after that same edge. The bench therefore drives every input on a falling edge and compares all outputs at the next falling edge against its own model, which it advances by one input per cycle. The checker module observes the same timing: the strobe must coincide with every fourth selection, and a cycle without input validity must be followed by a cycle with no selection.

// File: rtl/rs_pkg.sv
package rs_pkg;

    localparam int INT_W  = 4;
    localparam int FRAC_W = 12;
    localparam int IVL_W  = INT_W + FRAC_W;

    typedef logic [INT_W-1:0]  skip_t;
    typedef logic [FRAC_W-1:0] phase_t;

    typedef struct packed {
        skip_t  skip;   // valid inputs to pass over before the next pick
        phase_t phase;  // phase register after this pick
    } step_t;

    // Spacing decision taken at a selection: integer part (minimum one)
    // plus the carry out of the phase add.
    function automatic step_t next_step(phase_t phase, logic [IVL_W-1:0] ivl);
        skip_t          whole;
        logic [FRAC_W:0] sum;
        logic [INT_W:0]  adv;
        logic [INT_W:0]  less;
        whole = ivl[IVL_W-1:FRAC_W];
        if (whole == '0) whole = skip_t'(1);
        sum  = {1'b0, phase} + {1'b0, ivl[FRAC_W-1:0]};
        adv  = {1'b0, whole} + {{INT_W{1'b0}}, sum[FRAC_W]};
        less = adv - (INT_W+1)'(1);
        next_step.skip  = less[INT_W-1:0];
        next_step.phase = sum[FRAC_W-1:0];
    endfunction

endpackage

// File: rtl/rs_timing.sv
module rs_timing
    import rs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IVL_W-1:0] interval,
    output logic             pick,
    output phase_t           pick_phase
);

    skip_t  remain;
    phase_t phase;
    step_t  nxt;

    always_comb begin
        nxt        = next_step(phase, interval);
        pick       = in_valid && (remain == '0);
        pick_phase = phase;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
            phase  <= '0;
        end else if (in_valid) begin
            if (remain == '0) begin
                remain <= nxt.skip;
                phase  <= nxt.phase;
            end else begin
                remain <= remain - skip_t'(1);
            end
        end
    end

endmodule

// File: rtl/rs_stacker.sv
module rs_stacker #(
    parameter int DATA_W = 12,
    parameter int SLOTS  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    push,
    input  logic [DATA_W-1:0]       din,
    output logic                    sym_valid,
    output logic [SLOTS*DATA_W-1:0] sym_vec
);

    localparam int SLOT_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot      <= '0;
            sym_valid <= 1'b0;
        end else begin
            sym_valid <= push && (slot == LAST);
            if (push) slot <= (slot == LAST) ? '0 : slot + SLOT_W'(1);
        end
    end

    for (genvar i = 0; i < SLOTS; i++) begin : g_lane
        logic [DATA_W-1:0] lane;
        always_ff @(posedge clk) begin
            if (rst)                              lane <= '0;
            else if (push && slot == SLOT_W'(i))  lane <= din;
        end
        assign sym_vec[i*DATA_W +: DATA_W] = lane;
    end

endmodule

// File: rtl/symbol_sample_selector.sv
module symbol_sample_selector
    import rs_pkg::*;
#(
    parameter int DATA_W = 12,
    parameter int SLOTS  = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic [DATA_W-1:0]       in_data,
    input  logic [IVL_W-1:0]        interval,
    output logic                    sel_valid,
    output logic [DATA_W-1:0]       sel_data,
    output logic [FRAC_W-1:0]       sel_frac,
    output logic                    sym_valid,
    output logic [SLOTS*DATA_W-1:0] sym_vec
);

    logic   pick;
    phase_t pick_phase;

    rs_timing u_timing (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .interval   (interval),
        .pick       (pick),
        .pick_phase (pick_phase)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_valid <= 1'b0;
            sel_data  <= '0;
            sel_frac  <= '0;
        end else begin
            sel_valid <= pick;
            if (pick) begin
                sel_data <= in_data;
                sel_frac <= pick_phase;
            end
        end
    end

    rs_stacker #(.DATA_W(DATA_W), .SLOTS(SLOTS)) u_stack (
        .clk       (clk),
        .rst       (rst),
        .push      (pick),
        .din       (in_data),
        .sym_valid (sym_valid),
        .sym_vec   (sym_vec)
    );

endmodule

// File: rtl/rs_checker.sv
module rs_checker #(
    parameter int DATA_W = 12,
    parameter int FRAC_W = 12,
    parameter int SLOTS  = 4
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    sel_valid,
    input logic [DATA_W-1:0]       sel_data,
    input logic [FRAC_W-1:0]       sel_frac,
    input logic                    sym_valid,
    input logic [SLOTS*DATA_W-1:0] sym_vec
);

    localparam int CW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    logic [CW-1:0] seen;

    always_ff @(posedge clk) begin
        if (rst)            seen <= '0;
        else if (sel_valid) seen <= (seen == CW'(SLOTS - 1)) ? '0 : seen + CW'(1);
    end

    a_r2_no_pick_without_input: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !sel_valid);

    a_r7_strobe_on_fourth: assert property (@(posedge clk) disable iff (rst)
        sel_valid |-> (sym_valid == (seen == CW'(SLOTS - 1))));

    a_r7_strobe_needs_pick: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> sel_valid);

    a_r7_last_slot_newest: assert property (@(posedge clk) disable iff (rst)
        sym_valid |-> (sym_vec[SLOTS*DATA_W-1 -: DATA_W] == sel_data));

    a_r8_offset_holds: assert property (@(posedge clk) disable iff (rst)
        !sel_valid |-> ($stable(sel_frac) && $stable(sel_data)));

endmodule

bind symbol_sample_selector rs_checker #(
    .DATA_W (DATA_W),
    .FRAC_W (rs_pkg::FRAC_W),
    .SLOTS  (SLOTS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .sel_valid (sel_valid),
    .sel_data  (sel_data),
    .sel_frac  (sel_frac),
    .sym_valid (sym_valid),
    .sym_vec   (sym_vec)
);

// File: tb/symbol_sample_selector_test.sv
module symbol_sample_selector_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_data = '0;
    logic [15:0] interval = 16'h4000;
    logic        sel_valid;
    logic [11:0] sel_data;
    logic [11:0] sel_frac;
    logic        sym_valid;
    logic [47:0] sym_vec;

    int checks = 0;
    int fails  = 0;

    // bench model state
    int          m_remain = 0;
    int          m_phase  = 0;
    int          m_slot   = 0;
    logic [47:0] m_vec    = '0;
    logic [11:0] m_data   = '0;
    int          m_frac   = 0;
    int          picks    = 0;
    int          pick_at [$];
    int          in_idx   = 0;

    always #4 clk = ~clk;

    symbol_sample_selector uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .interval(interval), .sel_valid(sel_valid), .sel_data(sel_data),
        .sel_frac(sel_frac), .sym_valid(sym_valid), .sym_vec(sym_vec)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        m_remain = 0; m_phase = 0; m_slot = 0; m_data = '0; m_frac = 0;
        pick_at.delete(); in_idx = 0;
    endtask

    task automatic step(input logic v, input logic [11:0] d, input logic [15:0] ivl);
        logic e_sel = 1'b0;
        logic e_sym = 1'b0;
        int   whole;
        int   sum;
        in_valid = v; in_data = d; interval = ivl;
        if (v) begin
            if (m_remain == 0) begin
                e_sel  = 1'b1;
                m_data = d;
                m_frac = m_phase;
                whole  = int'(ivl[15:12]);
                if (whole == 0) whole = 1;
                sum    = m_phase + int'(ivl[11:0]);
                m_remain = whole + ((sum >= 4096) ? 1 : 0) - 1;
                m_phase  = sum % 4096;
                m_vec[m_slot*12 +: 12] = d;
                if (m_slot == 3) begin e_sym = 1'b1; m_slot = 0; end
                else m_slot++;
                picks++;
                pick_at.push_back(in_idx);
            end else begin
                m_remain--;
            end
            in_idx++;
        end
        @(posedge clk);
        @(negedge clk);
        check("R2/R8 sel_valid", 64'(sel_valid), 64'(e_sel));
        check("R7 sym_valid", 64'(sym_valid), 64'(e_sym));
        check("R8 sel_data", 64'(sel_data), 64'(m_data));
        check("R4 sel_frac", 64'(sel_frac), 64'(m_frac));
        if (e_sym) check("R7 sym_vec", 64'(sym_vec), 64'(m_vec));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        do_reset();
        // R1: reset state
        check("R1 sel_valid after reset", 64'(sel_valid), 64'd0);
        check("R1 sym_valid after reset", 64'(sym_valid), 64'd0);
        check("R1 sel_frac after reset", 64'(sel_frac), 64'd0);

        // R3: 4.3 spacing, continuous input
        for (int i = 0; i < 40; i++) step(1'b1, 12'(i + 1), 16'h44CD);
        check("R1 first pick index", 64'(pick_at[0]), 64'd0);
        check("R3 spacing 1", 64'(pick_at[1] - pick_at[0]), 64'd4);
        check("R3 spacing 3", 64'(pick_at[3] - pick_at[2]), 64'd4);
        check("R3 spacing 4 carries", 64'(pick_at[4] - pick_at[3]), 64'd5);

        // R2: gaps in input validity
        for (int i = 0; i < 60; i++) step(i % 3 != 1, 12'(100 + i), 16'h3800);

        // R5: integer part zero
        do_reset();
        for (int i = 0; i < 24; i++) step(1'b1, 12'(200 + i), 16'h0800);
        check("R5 spacing int0 a", 64'(pick_at[1] - pick_at[0]), 64'd1);
        check("R5 spacing int0 b", 64'(pick_at[2] - pick_at[1]), 64'd2);

        // R6: interval change while a skip is pending
        do_reset();
        step(1'b1, 12'h111, 16'h6000);
        for (int i = 0; i < 30; i++) step(1'b1, 12'(300 + i), 16'h2000);
        check("R6 old spacing kept", 64'(pick_at[1] - pick_at[0]), 64'd6);
        check("R6 new spacing used", 64'(pick_at[2] - pick_at[1]), 64'd2);

        // R3 boundary: largest spacing
        for (int i = 0; i < 80; i++) step(1'b1, 12'(i), 16'hFFFF);

        // R9: reset with a partly filled group
        do_reset();
        for (int i = 0; i < 6; i++) step(1'b1, 12'(400 + i), 16'h1000);
        do_reset();
        check("R9 sym_valid after mid reset", 64'(sym_valid), 64'd0);
        for (int i = 0; i < 8; i++) step(1'b1, 12'(500 + i), 16'h1000);

        // random mix
        begin
            logic [15:0] ivl = 16'h44CD;
            for (int i = 0; i < 4000; i++) begin
                if ($urandom % 50 == 0) ivl = 16'($urandom);
                step(($urandom % 4) != 0, 12'($urandom), ivl);
            end
        end
        check("R7 groups formed", 64'(picks > 40), 64'd1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule